// File: doc/BRIEF.md
# CAN Interrupt Pending Controller

This block gathers the interrupt requests of a CAN controller with fifteen message buffers and an error-management unit. Each buffer reports a finished transmission or reception with a one-cycle strobe. The transmit and receive error counters come in as plain values. Any change in either counter is treated as an error event. Every source has a sticky pending flag and a software enable. The single interrupt request line is the registered OR, over all sources, of pending AND enable.

Software reaches the block over a small register bus with four word addresses:

| Address | Word | Access |
|---|---|---|
| 0 | Enable | read and write |
| 1 | Pending | read-only |
| 2 | Clear | write-only, write one to clear |
| 3 | Reserved | reads zero |

All words share one bit layout: bits 14..0 are buffers 14..0, and bit 15 is the error source. A read returns its data one cycle after the request, marked by a valid strobe.

Top module: `canirq_ctrl`

## Requirements
- R1: A one-cycle strobe on buffer_done bit k sets pending bit k (k in 0..14) at that clock edge. Several strobes in one cycle set all their bits.
- R2: When the transmit or the receive error counter differs from its value in the previous cycle, pending bit 15 is set at the next edge. Counters that hold steady set nothing.
- R3: Pending bits latch whatever the state of their enable bits.
- R4: irq_o is high in the cycle after some bit has both pending and enable set. It is low in the cycle after no such bit exists.
- R5: A bus write to address 2 clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. Data bit 15 clears the error bit.
- R6: When a set event and a clear write reach the same pending bit in the same cycle, the bit ends up set.
- R7: A pending bit stays set over any number of cycles until a clear write names it.
- R8: A write to address 1 changes neither the pending word nor the enable word.
- R9: A read returns data with bus_rvalid_o high in the following cycle. Address 0 returns the enable word, address 1 the pending word, and addresses 2 and 3 return 0.
- R10: Reset clears every enable and pending bit and drops irq_o. It also loads the previous-counter copies with their reset values, which are 0 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_done_i | input | 15 | Per-buffer completion strobes |
| tec_i | input | 8 | Current transmit error counter |
| rec_i | input | 8 | Current receive error counter |
| bus_sel_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is held for at least two cycles. They also assume that error counter values entering during reset match the reset copies, so that no phantom change appears when reset is released. The stimulus sets both counters to zero before every reset. It changes a counter only between reads, and only to a new value, so that each intended error event stands alone. Buffer strobes are driven for exactly one cycle. They coincide with clear writes only where the set-over-clear case is exercised on purpose.

// File: rtl/canirq_pkg.sv
package canirq_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_PEND   = 2'd1,
        REG_CLEAR  = 2'd2,
        REG_RSVD   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     en_wr;
        logic     clr_wr;
        logic     rd;
        reg_sel_e rd_sel;
    } bus_op_t;

    function automatic bus_op_t decode_op(
        input logic              sel,
        input logic              we,
        input logic [ADDR_W-1:0] addr
    );
        bus_op_t op;
        op        = '0;
        op.rd_sel = reg_sel_e'(addr);
        if (sel) begin
            if (we) begin
                op.en_wr  = (reg_sel_e'(addr) == REG_ENABLE);
                op.clr_wr = (reg_sel_e'(addr) == REG_CLEAR);
            end else begin
                op.rd = 1'b1;
            end
        end
        return op;
    endfunction

endpackage

// File: rtl/canirq_errdet.sv
module canirq_errdet #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned TEC_RST = 0,
    parameter int unsigned REC_RST = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    output logic             evt_o
);
    localparam int unsigned NCNT = 2;

    logic [NCNT-1:0][CNT_W-1:0] now_val;
    logic [NCNT-1:0][CNT_W-1:0] rst_val;
    logic [NCNT-1:0]            diff;

    assign now_val = {rec_i, tec_i};
    assign rst_val = {CNT_W'(REC_RST), CNT_W'(TEC_RST)};

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        logic [CNT_W-1:0] prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= rst_val[c];
            else     prev_q <= now_val[c];
        end
        assign diff[c] = (now_val[c] != prev_q);
    end

    assign evt_o = |diff;
endmodule

// File: rtl/canirq_pend.sv
module canirq_pend #(
    parameter int unsigned SRC_N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] set_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [SRC_N-1:0] pend_o
);
    for (genvar b = 0; b < SRC_N; b++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)           bit_q <= 1'b0;
            else if (set_i[b]) bit_q <= 1'b1;
            else if (clr_i[b]) bit_q <= 1'b0;
        end
        assign pend_o[b] = bit_q;
    end
endmodule

// File: rtl/canirq_regs.sv
module canirq_regs
    import canirq_pkg::*;
#(
    parameter int unsigned SRC_N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [SRC_N-1:0]  bus_wdata_i,
    input  logic [SRC_N-1:0]  pend_i,
    output logic [SRC_N-1:0]  en_o,
    output logic [SRC_N-1:0]  clr_o,
    output logic [SRC_N-1:0]  rdata_o,
    output logic              rvalid_o
);
    bus_op_t          op;
    logic [SRC_N-1:0] en_q;
    logic [SRC_N-1:0] rd_mux;
    logic [SRC_N-1:0] rdata_q;
    logic             rvalid_q;

    always_comb op = decode_op(bus_sel_i, bus_we_i, bus_addr_i);

    always_comb begin
        case (op.rd_sel)
            REG_ENABLE: rd_mux = en_q;
            REG_PEND:   rd_mux = pend_i;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= op.rd;
            if (op.rd)    rdata_q <= rd_mux;
            if (op.en_wr) en_q    <= bus_wdata_i;
        end
    end

    assign clr_o    = op.clr_wr ? bus_wdata_i : '0;
    assign en_o     = en_q;
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
endmodule

// File: rtl/canirq_ctrl.sv
module canirq_ctrl
    import canirq_pkg::*;
#(
    parameter int unsigned NUM_BUF = 15,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned TEC_RST = 0,
    parameter int unsigned REC_RST = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BUF-1:0]   buf_done_i,
    input  logic [CNT_W-1:0]     tec_i,
    input  logic [CNT_W-1:0]     rec_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [NUM_BUF:0]     bus_wdata_i,
    output logic [NUM_BUF:0]     bus_rdata_o,
    output logic                 bus_rvalid_o,
    output logic                 irq_o
);
    localparam int unsigned SRC_N = NUM_BUF + 1;

    logic             err_evt;
    logic [SRC_N-1:0] set_vec;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] en_q;
    logic             irq_q;

    canirq_errdet #(
        .CNT_W  (CNT_W),
        .TEC_RST(TEC_RST),
        .REC_RST(REC_RST)
    ) u_errdet (
        .clk  (clk),
        .rst  (rst),
        .tec_i(tec_i),
        .rec_i(rec_i),
        .evt_o(err_evt)
    );

    assign set_vec = {err_evt, buf_done_i};

    canirq_pend #(.SRC_N(SRC_N)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .pend_o(pend_q)
    );

    canirq_regs #(.SRC_N(SRC_N)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel_i  (bus_sel_i),
        .bus_we_i   (bus_we_i),
        .bus_addr_i (bus_addr_i),
        .bus_wdata_i(bus_wdata_i),
        .pend_i     (pend_q),
        .en_o       (en_q),
        .clr_o      (clr_vec),
        .rdata_o    (bus_rdata_o),
        .rvalid_o   (bus_rvalid_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pend_q & en_q);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/canirq_chk.sv
module canirq_chk
    import canirq_pkg::*;
#(
    parameter int unsigned NUM_BUF = 15
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_BUF-1:0] buf_done,
    input logic               err_evt,
    input logic [NUM_BUF:0]   pend,
    input logic [NUM_BUF:0]   en,
    input logic [NUM_BUF:0]   clr,
    input logic               irq,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_BUF:0]   rdata,
    input logic               rvalid
);
    logic rst_d;

    // R1 / R6: every strobed buffer is pending after the edge, clear or not
    p_buf_set_r1: assert property (@(posedge clk) disable iff (rst)
        (|buf_done) |=> ((pend[NUM_BUF-1:0] & $past(buf_done)) == $past(buf_done)));

    // R2: a counter change event sets the error pending bit
    p_err_set_r2: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> pend[NUM_BUF]);

    // R5: cleared bits without a coincident set drop to zero
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (|clr) |=> ((pend & $past(clr) & ~$past({err_evt, buf_done})) == '0));

    // R7: a set bit not named by a clear stays set
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(pend) & ~$past(clr)) == ($past(pend) & ~$past(clr))));

    // R4: the request line follows masked pending one cycle later
    p_irq_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(pend) & $past(en))));

    // R9: reads of the clear word return zero with valid
    p_clr_read_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == REG_CLEAR) |=> (rvalid && rdata == '0));

    // R10: state is clear on the first cycle after reset
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && !rst) begin
            p_reset_r10: assert (irq == 1'b0 && pend == '0 && en == '0)
                else $error("reset state not clear");
        end
    end
endmodule

bind canirq_ctrl canirq_chk #(.NUM_BUF(NUM_BUF)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .buf_done(buf_done_i),
    .err_evt (err_evt),
    .pend    (pend_q),
    .en      (en_q),
    .clr     (clr_vec),
    .irq     (irq_o),
    .bus_sel (bus_sel_i),
    .bus_we  (bus_we_i),
    .bus_addr(bus_addr_i),
    .rdata   (bus_rdata_o),
    .rvalid  (bus_rvalid_o)
);

// File: tb/canirq_ctrl_test.sv
`timescale 1ns/1ps
module canirq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] buf_done = '0;
    logic [7:0]  tec = '0;
    logic [7:0]  rec = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    canirq_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .buf_done_i  (buf_done),
        .tec_i       (tec),
        .rec_i       (rec),
        .bus_sel_i   (bus_sel),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .bus_rvalid_o(bus_rvalid),
        .irq_o       (irq)
    );

    // Monitor: pops expected read data as read results appear
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rvalid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
                end else begin
                    logic [15:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bus_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s: read actual %h expected %h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic read_expect(input logic [1:0] a, input logic [15:0] e, input string t);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [14:0] v);
        buf_done = v;
        @(negedge clk);
        buf_done = '0;
    endtask

    task automatic check_irq(input logic e, input string t);
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic do_reset();
        tec = '0; rec = '0;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            if (exp_q.size() != 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL scoreboard: actual %0d reads outstanding expected 0", exp_q.size());
            end
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10: reset state
        check_irq(1'b0, "R10 irq after reset");
        read_expect(2'd0, 16'h0000, "R10 enable after reset");
        read_expect(2'd1, 16'h0000, "R10 pending after reset");

        // R1, R3: masked buffer still latches
        pulse(15'h0008);
        read_expect(2'd1, 16'h0008, "R3 latch while disabled");
        check_irq(1'b0, "R4 masked source");

        // R4: enabling raises request
        bus_write(2'd0, 16'h0008);
        idle(1);
        check_irq(1'b1, "R4 enabled source");
        read_expect(2'd0, 16'h0008, "R9 enable readback");

        // R1: several strobes at once
        pulse(15'h4001);
        read_expect(2'd1, 16'h4009, "R1 multi strobe");

        // R5 then R7
        bus_write(2'd2, 16'h0001);
        read_expect(2'd1, 16'h4008, "R5 selective clear");
        idle(20);
        read_expect(2'd1, 16'h4008, "R7 hold");
        check_irq(1'b1, "R7 irq held");

        // R8: pending word ignores writes
        bus_write(2'd1, 16'hFFFF);
        read_expect(2'd1, 16'h4008, "R8 pending unchanged");
        read_expect(2'd0, 16'h0008, "R8 enable unchanged");

        // R9: clear and reserved read zero
        read_expect(2'd2, 16'h0000, "R9 clear reads zero");
        read_expect(2'd3, 16'h0000, "R9 reserved reads zero");

        bus_write(2'd2, 16'h4008);
        idle(1);
        check_irq(1'b0, "R4 drop after clear");
        read_expect(2'd1, 16'h0000, "R5 clear all set bits");

        // R2: steady counters, then transmit counter change
        idle(10);
        read_expect(2'd1, 16'h0000, "R2 steady counters");
        tec = 8'h05;
        idle(1);
        read_expect(2'd1, 16'h8000, "R2 transmit counter change");
        check_irq(1'b0, "R3 error masked");
        bus_write(2'd0, 16'h8008);
        idle(1);
        check_irq(1'b1, "R4 error enabled");
        bus_write(2'd2, 16'h8000);
        idle(1);
        check_irq(1'b0, "R5 error bit cleared");

        // R2: receive counter change
        rec = 8'h01;
        idle(1);
        read_expect(2'd1, 16'h8000, "R2 receive counter change");
        bus_write(2'd2, 16'h8000);
        read_expect(2'd1, 16'h0000, "R5 bit 15 clear");

        // R6: set beats clear in the same cycle
        pulse(15'h0020);
        buf_done = 15'h0020;
        bus_write(2'd2, 16'h0020);
        buf_done = '0;
        read_expect(2'd1, 16'h0020, "R6 buffer set over clear");
        tec = 8'h06;
        bus_write(2'd2, 16'h8000);
        read_expect(2'd1, 16'h8020, "R6 error set over clear");
        bus_write(2'd2, 16'hFFFF);
        read_expect(2'd1, 16'h0000, "R5 clear everything");

        // R10: reset mid-run
        pulse(15'h0001);
        bus_write(2'd0, 16'h0001);
        idle(1);
        check_irq(1'b1, "R4 before reset");
        do_reset();
        check_irq(1'b0, "R10 irq after second reset");
        read_expect(2'd0, 16'h0000, "R10 enable cleared");
        read_expect(2'd1, 16'h0000, "R10 pending cleared");

        idle(3);
        finish_run();
    end
endmodule